// File: doc/BRIEF.md
# Three-Level Preemptive Interrupt Arbiter

This block sits between a set of interrupt request lines and a CPU. Each request line carries a two-bit priority code that either switches the line off or places it at the low, medium or high level. A separate non-maskable request ranks above every level. Every cycle the arbiter chooses one request to present. It drives the chosen line's index and its vector address, which is a base address plus a word offset. It also keeps a bitmap of the levels whose handlers are currently running, so that only a strictly higher level can interrupt a running handler.

The CPU accepts the presented request with an acknowledge pulse. It signals the end of a handler with a return strobe, which retires the most urgent running level. Within the low level an optional round-robin mode rotates the search start past the most recently accepted low-level line, so that no low-level source is starved. The medium and high levels always use a fixed order in which the lowest index wins.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, no request is presented (irqValid low) and all four bits of activeLevels are zero.
- R2: A line is a candidate only when its request bit is high, its level code is non-zero (1 = low, 2 = medium, 3 = high, 0 = off), and the enable bit for that level is set in levelEn (bit 0 low, bit 1 medium, bit 2 high). Any line that is not a candidate is ignored.
- R3: Among the candidates, the highest level wins. Within one level in fixed order (rrEn low, or any level above low), the lowest line index wins.
- R4: For a maskable request, vecIndex is the line index and vecAddr equals VEC_BASE + (index + 1) * VEC_STEP. For the non-maskable request, vecAddr equals VEC_BASE and vecIndex is zero.
- R5: While globalEn is low, no maskable request is presented.
- R6: An ack while irqValid is high sets the activeLevels bit of the presented level (bit 0 low, bit 1 medium, bit 2 high, bit 3 non-maskable) on the next clock edge.
- R7: A maskable request is presented only if its level is strictly above every active maskable level and the non-maskable handler is not active. A medium request preempts a running low handler, a high request preempts medium and low handlers, and an equal level never preempts.
- R8: A reti clears the highest set bit of activeLevels. If ack and reti occur in the same cycle, the clear applies to the old state and the bit of the presented level is then set.
- R9: The non-maskable request is presented whenever its activeLevels bit is clear, regardless of globalEn, levelEn and any active maskable level. While that bit is set, nothing is presented.
- R10: With rrEn high, the low-level search starts at the line after the most recently acknowledged low-level line and wraps from NUM_SRC-1 to 0. After reset, the search starts at line 0.
- R11: An ack while irqValid is low leaves activeLevels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | NUM_SRC | Request bit per line |
| reqLevel | input | 2*NUM_SRC | Two-bit level code per line, line i at bits 2i+1:2i |
| levelEn | input | 3 | Per-level enables: low, medium, high |
| globalEn | input | 1 | Global enable for maskable requests |
| rrEn | input | 1 | Round-robin enable for the low level |
| nmiReq | input | 1 | Non-maskable request |
| ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | CPU returns from the current handler |
| irqValid | output | 1 | A request is presented |
| irqNmi | output | 1 | The presented request is the non-maskable one |
| irqLevel | output | 2 | Level code of the presented maskable request, 0 otherwise |
| vecIndex | output | IDX_W | Line index of the presented request |
| vecAddr | output | ADDR_W | Vector address in words |
| activeLevels | output | 4 | Running-handler bitmap: low, medium, high, non-maskable |

## Verification
The bench builds the arbiter with NUM_SRC = 5, VEC_BASE = 0x100 and VEC_STEP = 2. Because five lines is not a power of two, the round-robin wrap has to be handled explicitly, and the test drives the rotation through indices 0, 2 and 4 and then back to 0. The non-zero base and the step of two make any error in the offset or in the NMI address visible on vecAddr. Nesting runs through all four active bits up to full saturation and then unwinds one level at a time.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MED  = 2'd2,
    LVL_HIGH = 2'd3
  } level_e;

  localparam int ACT_BITS = 4;
  localparam int ACT_NMI  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                present;
    logic                pickNmi;
    level_e              pickLevel;
    logic [ACT_BITS-1:0] setMask;
    logic [ACT_BITS-1:0] clrMask;
    logic                loadLast;
  } ctrl_strobe_t;

endpackage

// File: rtl/irq_arb_pick.sv
// Finds the first set bit of reqMask, scanning upward from startIdx with wrap.
module irq_arb_pick #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] reqMask,
  input  logic [IDX_W-1:0]   startIdx,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    int pos;
    found = 1'b0;
    idx   = '0;
    pos   = 0;
    for (int k = 0; k < NUM_SRC; k++) begin
      pos = int'(startIdx) + k;
      if (pos >= NUM_SRC) pos = pos - NUM_SRC;
      if (!found && reqMask[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter int          IDX_W    = 4,
  parameter int          ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 0,
  parameter int unsigned VEC_STEP = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    reqIn,
  input  logic [2*NUM_SRC-1:0]  reqLevel,
  input  logic [2:0]            levelEn,
  input  logic                  rrEn,
  input  ctrl_strobe_t          ctrl,
  output logic [2:0]            pend,
  output logic [ACT_BITS-1:0]   activeLevels,
  output logic [IDX_W-1:0]      vecIndex,
  output logic [ADDR_W-1:0]     vecAddr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic [2:0][NUM_SRC-1:0] lvlMask;
  logic [2:0][IDX_W-1:0]   pickIdx;
  logic [ACT_BITS-1:0]     activeQ;
  logic [IDX_W-1:0]        lastLowQ;
  logic [IDX_W-1:0]        nextLow;
  logic [IDX_W-1:0]        selIdx;

  assign nextLow = (lastLowQ == LAST_IDX) ? '0 : lastLowQ + IDX_W'(1);

  for (genvar lv = 0; lv < 3; lv++) begin : g_lvl
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign lvlMask[lv][i] = reqIn[i] && (reqLevel[2*i +: 2] == 2'(lv + 1)) && levelEn[lv];
    end

    logic [IDX_W-1:0] startIdx;
    if (lv == 0) begin : g_rot
      assign startIdx = rrEn ? nextLow : '0;
    end else begin : g_fix
      assign startIdx = '0;
    end

    irq_arb_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .reqMask  (lvlMask[lv]),
      .startIdx (startIdx),
      .found    (pend[lv]),
      .idx      (pickIdx[lv])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= '0;
      lastLowQ <= LAST_IDX;
    end else begin
      activeQ <= (activeQ & ~ctrl.clrMask) | ctrl.setMask;
      if (ctrl.loadLast) lastLowQ <= pickIdx[0];
    end
  end

  assign activeLevels = activeQ;

  always_comb begin
    selIdx  = '0;
    vecAddr = '0;
    if (ctrl.present && ctrl.pickNmi) begin
      vecAddr = ADDR_W'(VEC_BASE);
    end else if (ctrl.present) begin
      selIdx  = pickIdx[2'(ctrl.pickLevel) - 2'd1];
      vecAddr = ADDR_W'(VEC_BASE) + ADDR_W'((int'(selIdx) + 1) * int'(VEC_STEP));
    end
  end

  assign vecIndex = selIdx;

endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic                globalEn,
  input  logic                nmiReq,
  input  logic                ack,
  input  logic                reti,
  input  logic [2:0]          pend,
  input  logic [ACT_BITS-1:0] activeLevels,
  output ctrl_strobe_t        ctrl
);

  logic [1:0] actTop;

  always_comb begin
    if (activeLevels[2])      actTop = 2'd3;
    else if (activeLevels[1]) actTop = 2'd2;
    else if (activeLevels[0]) actTop = 2'd1;
    else                      actTop = 2'd0;
  end

  always_comb begin
    ctrl = '{present: 1'b0, pickNmi: 1'b0, pickLevel: LVL_OFF,
             setMask: '0, clrMask: '0, loadLast: 1'b0};

    if (nmiReq && !activeLevels[ACT_NMI]) begin
      ctrl.present = 1'b1;
      ctrl.pickNmi = 1'b1;
    end else if (globalEn && !activeLevels[ACT_NMI]) begin
      for (int lv = 3; lv >= 1; lv--) begin
        if (!ctrl.present && pend[lv-1] && (2'(lv) > actTop)) begin
          ctrl.present   = 1'b1;
          ctrl.pickLevel = level_e'(2'(lv));
        end
      end
    end

    if (reti) begin
      if (activeLevels[3])      ctrl.clrMask = 4'b1000;
      else if (activeLevels[2]) ctrl.clrMask = 4'b0100;
      else if (activeLevels[1]) ctrl.clrMask = 4'b0010;
      else if (activeLevels[0]) ctrl.clrMask = 4'b0001;
    end

    if (ack && ctrl.present) begin
      if (ctrl.pickNmi) ctrl.setMask = 4'b1000;
      else              ctrl.setMask = 4'b0001 << (2'(ctrl.pickLevel) - 2'd1);
      ctrl.loadLast = !ctrl.pickNmi && (ctrl.pickLevel == LVL_LOW);
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter int          ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 0,
  parameter int unsigned VEC_STEP = 2,
  localparam int         IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   reqIn,
  input  logic [2*NUM_SRC-1:0] reqLevel,
  input  logic [2:0]           levelEn,
  input  logic                 globalEn,
  input  logic                 rrEn,
  input  logic                 nmiReq,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irqValid,
  output logic                 irqNmi,
  output logic [1:0]           irqLevel,
  output logic [IDX_W-1:0]     vecIndex,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic [3:0]           activeLevels
);

  ctrl_strobe_t ctrl;
  logic [2:0]   pend;

  irq_arb_control u_ctrl (
    .globalEn     (globalEn),
    .nmiReq       (nmiReq),
    .ack          (ack),
    .reti         (reti),
    .pend         (pend),
    .activeLevels (activeLevels),
    .ctrl         (ctrl)
  );

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .reqLevel     (reqLevel),
    .levelEn      (levelEn),
    .rrEn         (rrEn),
    .ctrl         (ctrl),
    .pend         (pend),
    .activeLevels (activeLevels),
    .vecIndex     (vecIndex),
    .vecAddr      (vecAddr)
  );

  assign irqValid = ctrl.present;
  assign irqNmi   = ctrl.pickNmi;
  assign irqLevel = 2'(ctrl.pickLevel);

endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker (
  input logic       clk,
  input logic       rstN,
  input logic       globalEn,
  input logic       nmiReq,
  input logic       ack,
  input logic       reti,
  input logic       irqValid,
  input logic       irqNmi,
  input logic [1:0] irqLevel,
  input logic [3:0] activeLevels
);

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && !activeLevels[3]) |-> (irqValid && irqNmi)); // R9

  AST_NMI_NO_REENTRY: assert property (@(posedge clk) disable iff (!rstN)
    activeLevels[3] |-> !irqValid); // R9

  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !irqNmi) |-> !irqValid); // R5

  AST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !irqNmi) |->
      ((irqLevel != 2'd0) && !activeLevels[3] &&
       ((activeLevels[2:0] >> (irqLevel - 2'd1)) == 3'b000))); // R7

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqValid && !reti) |=>
      ($countones(activeLevels) == $countones($past(activeLevels)) + 1)); // R6

  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (reti && !ack && (activeLevels != 4'b0000)) |=>
      ($countones(activeLevels) == $countones($past(activeLevels)) - 1)); // R8

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !irqValid && !reti) |=> $stable(activeLevels)); // R11

endmodule

bind irq_arbiter irq_arbiter_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .globalEn     (globalEn),
  .nmiReq       (nmiReq),
  .ack          (ack),
  .reti         (reti),
  .irqValid     (irqValid),
  .irqNmi       (irqNmi),
  .irqLevel     (irqLevel),
  .activeLevels (activeLevels)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;

  localparam int NSRC = 5;
  localparam int AW   = 16;
  localparam int IW   = 3;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NSRC-1:0] reqIn;
  logic [2*NSRC-1:0] reqLevel;
  logic [2:0]      levelEn;
  logic            globalEn, rrEn, nmiReq, ack, reti;
  logic            irqValid, irqNmi;
  logic [1:0]      irqLevel;
  logic [IW-1:0]   vecIndex;
  logic [AW-1:0]   vecAddr;
  logic [3:0]      activeLevels;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  irq_arbiter #(.NUM_SRC(NSRC), .ADDR_W(AW), .VEC_BASE(32'h100), .VEC_STEP(2)) uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .reqLevel(reqLevel), .levelEn(levelEn),
    .globalEn(globalEn), .rrEn(rrEn), .nmiReq(nmiReq), .ack(ack), .reti(reti),
    .irqValid(irqValid), .irqNmi(irqNmi), .irqLevel(irqLevel), .vecIndex(vecIndex),
    .vecAddr(vecAddr), .activeLevels(activeLevels)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0; reqIn = '0; reqLevel = '0; levelEn = 3'b111;
    globalEn = 1'b1; rrEn = 1'b0; nmiReq = 1'b0; ack = 1'b0; reti = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic setLine(int i, logic [1:0] lvl);
    reqIn[i] = 1'b1;
    reqLevel[2*i +: 2] = lvl;
    #1;
  endtask

  task automatic pulse(logic doAck, logic doReti);
    @(negedge clk);
    ack = doAck; reti = doReti;
    @(negedge clk);
    ack = 1'b0; reti = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    resetDut();
    check("R1", "irqValid", 32'(irqValid), 0);
    check("R1", "activeLevels", 32'(activeLevels), 0);
  endtask

  task automatic t_eligible();
    resetDut();
    setLine(2, 2'd0);
    check("R2", "level off ignored", 32'(irqValid), 0);
    levelEn = 3'b110;
    setLine(2, 2'd1);
    check("R2", "level disabled ignored", 32'(irqValid), 0);
    levelEn = 3'b111; #1;
    check("R2", "enabled valid", 32'(irqValid), 1);
    check("R2", "enabled index", 32'(vecIndex), 2);
  endtask

  task automatic t_priority();
    resetDut();
    setLine(1, 2'd1); setLine(4, 2'd2); setLine(3, 2'd2);
    check("R3", "level", 32'(irqLevel), 2);
    check("R3", "lowest index", 32'(vecIndex), 3);
    check("R4", "vecAddr", 32'(vecAddr), 32'h108);
  endtask

  task automatic t_global();
    resetDut();
    setLine(0, 2'd3);
    globalEn = 1'b0; #1;
    check("R5", "masked", 32'(irqValid), 0);
    levelEn = 3'b000; nmiReq = 1'b1; #1;
    check("R9", "nmi valid", 32'(irqValid), 1);
    check("R9", "nmi flag", 32'(irqNmi), 1);
    check("R4", "nmi vecAddr", 32'(vecAddr), 32'h100);
    check("R4", "nmi vecIndex", 32'(vecIndex), 0);
  endtask

  task automatic t_nesting();
    resetDut();
    setLine(0, 2'd1);
    pulse(1'b1, 1'b0);
    check("R6", "low active", 32'(activeLevels), 4'b0001);
    check("R7", "equal no preempt", 32'(irqValid), 0);
    setLine(1, 2'd2);
    check("R7", "med preempts", 32'(irqLevel), 2);
    pulse(1'b1, 1'b0);
    check("R6", "med active", 32'(activeLevels), 4'b0011);
    setLine(2, 2'd3);
    check("R7", "high preempts", 32'(irqLevel), 3);
    check("R4", "high vecAddr", 32'(vecAddr), 32'h106);
    pulse(1'b1, 1'b0);
    check("R6", "high active", 32'(activeLevels), 4'b0111);
    nmiReq = 1'b1; #1;
    check("R9", "nmi over high", 32'(irqNmi), 1);
    pulse(1'b1, 1'b0);
    check("R6", "nmi active", 32'(activeLevels), 4'b1111);
    check("R9", "nmi no reentry", 32'(irqValid), 0);
    pulse(1'b0, 1'b1);
    check("R8", "reti clears nmi", 32'(activeLevels), 4'b0111);
    pulse(1'b0, 1'b1);
    check("R8", "reti clears high", 32'(activeLevels), 4'b0011);
  endtask

  task automatic t_idle_ack();
    resetDut();
    pulse(1'b1, 1'b0);
    check("R11", "ack without request", 32'(activeLevels), 0);
  endtask

  task automatic t_ack_reti();
    resetDut();
    setLine(0, 2'd1);
    pulse(1'b1, 1'b0);
    setLine(3, 2'd2);
    pulse(1'b1, 1'b1);
    check("R8", "reti with ack", 32'(activeLevels), 4'b0010);
  endtask

  task automatic t_roundrobin();
    resetDut();
    rrEn = 1'b1;
    setLine(0, 2'd1); setLine(2, 2'd1); setLine(4, 2'd1);
    check("R10", "first low", 32'(vecIndex), 0);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
    check("R10", "rotate to 2", 32'(vecIndex), 2);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
    check("R10", "rotate to 4", 32'(vecIndex), 4);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
    check("R10", "wrap to 0", 32'(vecIndex), 0);
    check("R4", "wrap vecAddr", 32'(vecAddr), 32'h102);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
    rrEn = 1'b0; #1;
    check("R3", "fixed order returns to 0", 32'(vecIndex), 0);
  endtask

  initial begin
    #(20 * 200000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    t_reset();
    t_eligible();
    t_priority();
    t_global();
    t_nesting();
    t_idle_ack();
    t_ack_reti();
    t_roundrobin();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule